// File: doc/BRIEF.md
# Programmable CPU Address Window Decoder

This block looks at a 32-bit CPU address and picks the one target that the transfer is routed to. It holds thirteen windows. Four belong to the DRAM chip selects, one to the internal register space, and eight are general purpose for the other on-chip resources. Each window keeps a base value, a size mask and an enable bit. Software loads these through a simple write port that has one register per window field. The decode itself is purely combinational. It returns a one-hot target select, the number of the selected window, and a miss flag.

The DRAM windows work in 16MB units on address bits [31:24]. The general-purpose windows work in 64KB units on bits [31:16]. The register window has a fixed 1MB size, so its base is matched against bits [31:20]. A size mask is accepted only when it is a contiguous run of ones starting at bit 0. A write with any other mask value leaves the window unchanged and sets a sticky error flag. When several enabled windows hit the same address, a fixed precedence chooses one of them.

Top module: `addr_win_decoder`

## Requirements
- R1: After reset, DRAM window i (i = 0..3) is enabled with base i*0x10 and size mask 0x0F, so it covers 256MB from i*0x10000000. The register window is enabled at 0xD0000000. All general-purpose windows are disabled. The size error flag is 0.
- R2: A write is done with wr_en=1 and wr_win set to the window number: 0..3 for DRAM, 4 for the register window, 5..12 for general purpose. Values 13..15 are ignored. wr_field selects 0 for base, 1 for size or 2 for enable (wr_data bit 0), and 3 is ignored. Base and size take the low field-width bits of wr_data. The write is visible to the decode from the clock edge that captures it, and not before.
- R3: An enabled window hits when the compared address field and the base agree in every bit where the size mask is 0. A disabled window never hits.
- R4: DRAM windows compare address bits [31:24] with an 8-bit base and mask, so a window covers (mask+1) x 16MB. Mask 0xFF covers all 4GB.
- R5: General-purpose windows compare address bits [31:16] with a 16-bit base and mask, so a window covers (mask+1) x 64KB. Mask 0xFFFF covers all 4GB.
- R6: The register window compares address bits [31:20] against a 12-bit base and always covers exactly 1MB. Size writes to it change nothing and raise no error.
- R7: A size write whose masked value is zero or is not a contiguous run of low-order ones is discarded, and the size error flag goes to 1. The flag stays at 1 until reset, even after later legal writes.
- R8: When several windows hit, the register window wins first. After it come the DRAM windows, lowest number first, and then the general-purpose windows, lowest number first.
- R9: When no enabled window hits, miss=1, tgt_sel=0 and tgt_idx=0.
- R10: When some window hits, miss=0, tgt_sel has exactly the bit of the winning window number set, and tgt_idx equals that number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Window register write strobe |
| wr_win | input | 4 | Window number being written |
| wr_field | input | 2 | Field written: 0 base, 1 size, 2 enable |
| wr_data | input | 16 | Write data |
| addr | input | 32 | CPU address to decode |
| tgt_sel | output | 13 | One-hot target select, bit = window number |
| tgt_idx | output | 4 | Number of the winning window |
| miss | output | 1 | No enabled window hits the address |
| size_err | output | 1 | Sticky flag for a rejected size write |

## Verification
The precedence rules are the hardest behaviour to reach. At reset no two windows overlap, so the bench has to reprogram several windows until they cover the same addresses. It enlarges DRAM 1 over DRAM 0, places one general-purpose window on top of the register window, stacks two general-purpose windows, and finally enables a 4GB catch-all window at the lowest precedence. After each of these setups it sweeps the top address byte, and the bits [23:16] around each overlap, against a decode model built from the requirements. Rejected size writes are checked the same way. Sweeping again after a rejected write shows at the decode outputs that the old mask is still in force.

// File: rtl/addr_win_pkg.sv
// Shared definitions for the address window decoder.
// Assumes: the write port field selector is two bits wide.
package addr_win_pkg;

    // Field selector of the window register write port.
    typedef enum logic [1:0] {
        FLD_BASE   = 2'd0,
        FLD_SIZE   = 2'd1,
        FLD_ENABLE = 2'd2,
        FLD_NONE   = 2'd3
    } win_field_e;

endpackage

// File: rtl/aw_mask_check.sv
// Size mask legality check.
// A mask is legal when it is nonzero and is a contiguous run of ones
// starting at bit 0. Assumes FW >= 1. Purely combinational.
module aw_mask_check #(
    parameter int FW = 8
) (
    input  logic [FW-1:0] mask,
    output logic          legal
);

    logic [FW-1:0] mask_inc;

    // Adding one to a low-order run of ones clears every set bit.
    always_comb begin
        mask_inc = mask + {{(FW-1){1'b0}}, 1'b1};
        legal    = (mask != '0) && ((mask & mask_inc) == '0);
    end

endmodule

// File: rtl/aw_window.sv
// One decode window: base, size mask and enable registers plus the hit test.
// When FIXED is set, the window has no size register: its mask is zero and
// size writes are dropped without an error. Assumes the parent has already
// qualified wr_en with the window number.
module aw_window
    import addr_win_pkg::*;
#(
    parameter int            FW       = 8,
    parameter bit            FIXED    = 1'b0,
    parameter logic [FW-1:0] RST_BASE = '0,
    parameter logic [FW-1:0] RST_SIZE = '0,
    parameter bit            RST_EN   = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  win_field_e    wr_field,
    input  logic [FW-1:0] wr_data,
    input  logic [FW-1:0] addr_field,
    output logic          hit,
    output logic          size_bad
);

    logic [FW-1:0] base_q;
    logic [FW-1:0] size_q;
    logic          en_q;

    // Base and enable registers, written through the window write port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= RST_BASE;
            en_q   <= RST_EN;
        end else if (wr_en) begin
            if (wr_field == FLD_BASE)   base_q <= wr_data;
            if (wr_field == FLD_ENABLE) en_q   <= wr_data[0];
        end
    end

    generate
        if (FIXED) begin : g_fixed
            // Fixed size: exact match on the whole field.
            assign size_q   = '0;
            assign size_bad = 1'b0;
        end else begin : g_prog
            logic size_legal;
            logic size_wr;

            aw_mask_check #(.FW(FW)) u_chk (
                .mask  (wr_data),
                .legal (size_legal)
            );

            // Flags a size write to this window.
            assign size_wr  = wr_en && (wr_field == FLD_SIZE);
            assign size_bad = size_wr && !size_legal;

            // Size register: only legal masks are accepted.
            always_ff @(posedge clk) begin
                if (!rst_n)                     size_q <= RST_SIZE;
                else if (size_wr && size_legal) size_q <= wr_data;
            end

            AST_BAD_SIZE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
                size_bad |=> $stable(size_q)); // R7
            AST_SIZE_ALWAYS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
                ((size_q & (size_q + 1'b1)) == '0) && (size_q != '0)); // R7
        end
    endgenerate

    // Hit when every unmasked field bit agrees with the base.
    always_comb begin
        hit = en_q && (((addr_field ^ base_q) & ~size_q) == '0);
    end

    AST_BASE_WRITE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_field == FLD_BASE) |=> (base_q == $past(wr_data))); // R2
    AST_DISABLED_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> !hit); // R3

endmodule

// File: rtl/aw_prio.sv
// Fixed-precedence selector over the window hit vector.
// Precedence: the register window (number N_DRAM), then DRAM windows
// 0..N_DRAM-1, then general-purpose windows in rising number.
// clk and rst_n serve only the embedded assertions.
module aw_prio #(
    parameter int N_DRAM = 4,
    parameter int N_CFG  = 8,
    parameter int IDX_W  = 4,
    localparam int N_WIN = N_DRAM + 1 + N_CFG
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_WIN-1:0] hit,
    output logic [N_WIN-1:0] sel,
    output logic [IDX_W-1:0] idx,
    output logic             miss
);

    // Maps a precedence rank to a window number.
    function automatic int rank_to_win(input int k);
        if (k == 0)      return N_DRAM;
        if (k <= N_DRAM) return k - 1;
        return k;
    endfunction

    // Scans from lowest to highest precedence so the strongest hit is kept.
    always_comb begin
        sel = '0;
        idx = '0;
        for (int k = N_WIN - 1; k >= 0; k--) begin
            if (hit[rank_to_win(k)]) begin
                sel                 = '0;
                sel[rank_to_win(k)] = 1'b1;
                idx                 = IDX_W'(rank_to_win(k));
            end
        end
        miss = (hit == '0);
    end

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        !miss |-> $onehot(sel)); // R10
    AST_MISS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        miss |-> (sel == '0 && idx == '0)); // R9
    AST_REG_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        hit[N_DRAM] |-> sel[N_DRAM]); // R8

endmodule

// File: rtl/addr_win_decoder.sv
// Programmable CPU address window decoder (top).
// Window numbers: 0..N_DRAM-1 DRAM, N_DRAM the register window, the rest
// general purpose. Decode is combinational. Register writes land at the
// clock edge that samples them. Assumes wr_data is at least CFG_FW wide.
module addr_win_decoder
    import addr_win_pkg::*;
#(
    parameter int               ADDR_W        = 32,
    parameter int               DATA_W        = 16,
    parameter int               N_DRAM        = 4,
    parameter int               N_CFG         = 8,
    parameter int               DRAM_FW       = 8,
    parameter int               CFG_FW        = 16,
    parameter int               REG_FW        = 12,
    parameter logic [DRAM_FW-1:0] DRAM_RST_SIZE = 8'h0F,
    parameter logic [REG_FW-1:0]  REG_RST_BASE  = 12'hD00,
    localparam int              N_WIN         = N_DRAM + 1 + N_CFG,
    localparam int              IDX_W         = $clog2(N_WIN),
    localparam int              LOW_W         = ADDR_W - CFG_FW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_win,
    input  logic [1:0]        wr_field,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] addr,
    output logic [N_WIN-1:0]  tgt_sel,
    output logic [IDX_W-1:0]  tgt_idx,
    output logic              miss,
    output logic              size_err
);

    logic [N_WIN-1:0] win_hit;
    logic [N_WIN-1:0] win_bad;
    logic [N_WIN-1:0] win_wr;
    win_field_e       field;
    logic             size_err_q;
    logic             unused_addr_low;

    // Bits below the finest window granularity take no part in decode.
    assign unused_addr_low = ^addr[LOW_W-1:0];
    assign field           = win_field_e'(wr_field);

    // Per-window write strobe from the window number.
    always_comb begin
        for (int w = 0; w < N_WIN; w++) begin
            win_wr[w] = wr_en && (wr_win == IDX_W'(w));
        end
    end

    generate
        for (genvar w = 0; w < N_WIN; w++) begin : g_win
            if (w < N_DRAM) begin : g_dram
                aw_window #(
                    .FW       (DRAM_FW),
                    .FIXED    (1'b0),
                    .RST_BASE (DRAM_FW'(w * (int'(DRAM_RST_SIZE) + 1))),
                    .RST_SIZE (DRAM_RST_SIZE),
                    .RST_EN   (1'b1)
                ) u_win (
                    .clk        (clk),
                    .rst_n      (rst_n),
                    .wr_en      (win_wr[w]),
                    .wr_field   (field),
                    .wr_data    (wr_data[DRAM_FW-1:0]),
                    .addr_field (addr[ADDR_W-1 -: DRAM_FW]),
                    .hit        (win_hit[w]),
                    .size_bad   (win_bad[w])
                );
            end else if (w == N_DRAM) begin : g_regs
                aw_window #(
                    .FW       (REG_FW),
                    .FIXED    (1'b1),
                    .RST_BASE (REG_RST_BASE),
                    .RST_SIZE ('0),
                    .RST_EN   (1'b1)
                ) u_win (
                    .clk        (clk),
                    .rst_n      (rst_n),
                    .wr_en      (win_wr[w]),
                    .wr_field   (field),
                    .wr_data    (wr_data[REG_FW-1:0]),
                    .addr_field (addr[ADDR_W-1 -: REG_FW]),
                    .hit        (win_hit[w]),
                    .size_bad   (win_bad[w])
                );
            end else begin : g_cfg
                aw_window #(
                    .FW       (CFG_FW),
                    .FIXED    (1'b0),
                    .RST_BASE ('0),
                    .RST_SIZE (CFG_FW'(1)),
                    .RST_EN   (1'b0)
                ) u_win (
                    .clk        (clk),
                    .rst_n      (rst_n),
                    .wr_en      (win_wr[w]),
                    .wr_field   (field),
                    .wr_data    (wr_data[CFG_FW-1:0]),
                    .addr_field (addr[ADDR_W-1 -: CFG_FW]),
                    .hit        (win_hit[w]),
                    .size_bad   (win_bad[w])
                );
            end

            AST_SEL_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
                tgt_sel[w] |-> win_hit[w]); // R3
        end
    endgenerate

    aw_prio #(
        .N_DRAM (N_DRAM),
        .N_CFG  (N_CFG),
        .IDX_W  (IDX_W)
    ) u_prio (
        .clk   (clk),
        .rst_n (rst_n),
        .hit   (win_hit),
        .sel   (tgt_sel),
        .idx   (tgt_idx),
        .miss  (miss)
    );

    // Sticky record of any rejected size write.
    always_ff @(posedge clk) begin
        if (!rst_n) size_err_q <= 1'b0;
        else        size_err_q <= size_err_q | (|win_bad);
    end

    assign size_err = size_err_q;

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        size_err |=> size_err); // R7
    AST_ERR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (|win_bad) |=> size_err); // R7
    AST_REG_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        !win_bad[N_DRAM]); // R6

endmodule

// File: tb/addr_win_decoder_test.sv
// Self-checking bench: sweeps of the address space against a decode model
// built from the requirements, under several window programmings.
module addr_win_decoder_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_win = '0;
    logic [1:0]  wr_field = '0;
    logic [15:0] wr_data = '0;
    logic [31:0] addr = '0;
    logic [12:0] tgt_sel;
    logic [3:0]  tgt_idx;
    logic        miss;
    logic        size_err;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    int m_base [13];
    int m_size [13];
    bit m_en   [13];
    bit m_err;

    always #10 clk = ~clk;

    addr_win_decoder uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_win(wr_win),
        .wr_field(wr_field), .wr_data(wr_data), .addr(addr),
        .tgt_sel(tgt_sel), .tgt_idx(tgt_idx), .miss(miss), .size_err(size_err)
    );

    function automatic int fw_of(input int w);
        if (w < 4)  return 8;
        if (w == 4) return 12;
        return 16;
    endfunction

    function automatic int fmask(input int w);
        return (1 << fw_of(w)) - 1;
    endfunction

    function automatic bit legal_mask(input int v, input int w);
        int m = v & fmask(w);
        return (m != 0) && ((m & (m + 1)) == 0);
    endfunction

    function automatic int rank_win(input int k);
        if (k == 0) return 4;
        if (k <= 4) return k - 1;
        return k;
    endfunction

    // Expected winning window, -1 on a miss.
    function automatic int exp_win(input logic [31:0] a);
        for (int k = 0; k < 13; k++) begin
            int w = rank_win(k);
            int f = int'(a >> (32 - fw_of(w)));
            if (m_en[w] && (((f ^ m_base[w]) & ~m_size[w] & fmask(w)) == 0))
                return w;
        end
        return -1;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 13; i++) begin
            m_base[i] = (i < 4) ? i * 16 : 0;
            m_size[i] = (i < 4) ? 15 : ((i == 4) ? 0 : 1);
            m_en[i]   = (i < 5);
        end
        m_base[4] = 12'hD00;
        m_err = 1'b0;
    endtask

    task automatic fail_line(input string req, input string what, input int act, input int exp);
        failures++;
        $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    endtask

    // Decode check of one address at a quiet point of the clock.
    task automatic chk_addr(input logic [31:0] a, input string req);
        int e;
        logic [12:0] es;
        addr = a;
        #1;
        e = exp_win(a);
        es = (e < 0) ? 13'd0 : 13'(1 << e);
        checks++;
        if (miss !== (e < 0) || tgt_sel !== es || tgt_idx !== ((e < 0) ? 4'd0 : 4'(e))) begin
            fail_line(req, $sformatf("addr=%08h sel/idx/miss", a),
                      {tgt_sel, tgt_idx, miss}, {es, (e < 0) ? 4'd0 : 4'(e), e < 0});
        end
    endtask

    task automatic chk_err(input string req);
        checks++;
        if (size_err !== m_err) fail_line(req, "size_err", size_err, m_err);
    endtask

    // Top address byte sweep.
    task automatic sweep_coarse(input string req);
        for (int b = 0; b < 256; b++) chk_addr({8'(b), 24'h3C5A5A}, req);
    endtask

    // Bits [23:16] sweep under a fixed top byte.
    task automatic sweep_fine(input logic [7:0] top, input string req);
        for (int v = 0; v < 256; v++) chk_addr({top, 8'(v), 16'hA5C3}, req);
    endtask

    // One register write plus the model update defined by R2, R6 and R7.
    task automatic wr(input int w, input int fld, input int data);
        @(negedge clk);
        wr_en = 1'b1; wr_win = 4'(w); wr_field = 2'(fld); wr_data = 16'(data);
        @(negedge clk);
        wr_en = 1'b0;
        if (w < 13) begin
            if (fld == 0) m_base[w] = data & fmask(w);
            else if (fld == 1 && w != 4) begin
                if (legal_mask(data, w)) m_size[w] = data & fmask(w);
                else m_err = 1'b1;
            end else if (fld == 2) m_en[w] = data[0];
        end
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset map, R4 DRAM granularity, R9 misses in the gaps
        chk_err("R1");
        sweep_coarse("R1");
        sweep_fine(8'hD0, "R6");
        sweep_fine(8'h3F, "R4");

        // R2 write timing: enable takes effect only at the capturing edge
        wr(5, 0, 16'h8012);
        wr(5, 1, 16'h0003);
        chk_addr(32'h8012_0000, "R3");
        @(negedge clk);
        wr_en = 1'b1; wr_win = 4'd5; wr_field = 2'd2; wr_data = 16'h0001;
        chk_addr(32'h8012_0000, "R2");
        @(posedge clk);
        #1;
        checks++;
        if (miss !== 1'b0 || tgt_idx !== 4'd5) fail_line("R2", "enable after edge", {miss, tgt_idx}, 5);
        @(negedge clk);
        wr_en = 1'b0;
        m_en[5] = 1'b1;
        sweep_fine(8'h80, "R5");

        // R2 ignored field code and out-of-range window number
        wr(6, 3, 16'hFFFF);
        wr(14, 2, 16'h0001);
        sweep_fine(8'h80, "R2");

        // R8 overlaps: DRAM1 over DRAM0, cfg over the register window, cfg over cfg
        wr(1, 0, 16'h0000);
        wr(1, 1, 16'h001F);
        wr(6, 0, 16'hD000);
        wr(6, 1, 16'h00FF);
        wr(6, 2, 16'h0001);
        wr(7, 0, 16'h8000);
        wr(7, 1, 16'h00FF);
        wr(7, 2, 16'h0001);
        wr(8, 0, 16'h0000);
        wr(8, 1, 16'h0FFF);
        wr(8, 2, 16'h0001);
        sweep_coarse("R8");
        sweep_fine(8'hD0, "R8");
        sweep_fine(8'h80, "R8");
        chk_err("R7");

        // R6 register window: size write dropped without error, then relocation
        wr(4, 1, 16'h0005);
        chk_err("R6");
        sweep_fine(8'hD0, "R6");
        wr(4, 0, 16'h0F10);
        sweep_fine(8'hF1, "R6");
        sweep_fine(8'hD0, "R6");

        // R7 rejected masks keep the old window and set the sticky flag
        wr(5, 1, 16'h0005);
        chk_err("R7");
        sweep_fine(8'h80, "R7");
        wr(0, 1, 16'h0100);
        chk_err("R7");
        sweep_coarse("R7");
        wr(5, 1, 16'h000F);
        chk_err("R7");
        sweep_fine(8'h80, "R7");

        // R4 largest DRAM mask, R9 with DRAM windows disabled
        wr(2, 1, 16'h00FF);
        sweep_coarse("R4");
        for (int i = 0; i < 4; i++) wr(i, 2, 16'h0000);
        sweep_coarse("R9");

        // R5 largest general-purpose mask: catch-all at lowest precedence
        wr(12, 0, 16'h1234);
        wr(12, 1, 16'hFFFF);
        wr(12, 2, 16'h0001);
        sweep_coarse("R10");
        sweep_fine(8'hF1, "R10");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule